// File: doc/BRIEF.md
# Double-Precision to Integer Converter (Truncating)

This block takes a 64-bit binary floating-point value and turns it into an integer by rounding toward zero. A 2-bit format code picks one of four destinations: 32-bit signed, 32-bit unsigned, 64-bit signed or 64-bit unsigned. The block returns a 64-bit integer result, an invalid flag and an inexact flag. Zeros, subnormals, normals, infinities and NaNs are all handled. Any value that does not fit the chosen format is clamped to that format's limit.

The converter is a short pipeline. A conversion starts in any cycle where `in_valid` is high, so a new operand can be accepted on every clock. Its result appears with `out_valid` a fixed number of cycles later. Parameters set the floating-point field widths and the integer width. A further parameter adds or removes the register between the magnitude stage and the clamping stage.

Top module: `d2i_convert`

## Requirements
- R1: In-range values are truncated toward zero. For example, 1.1 gives 1, -1.1 gives -1, and both 0.9 and -0.9 give 0.
- R2: When the result is in range and a nonzero fraction was discarded, `out_inexact` is set. An exact conversion such as 1.0 or -1.0 raises neither flag.
- R3: A signed conversion whose truncated value lies outside the format's range clamps to the signed minimum (negative inputs) or the signed maximum (positive inputs) and sets `out_invalid`. The bounds are -2^31 and 2^31-1 for 32 bits, and -2^63 and 2^63-1 for 64 bits.
- R4: An unsigned conversion whose truncated value is negative (for example -1.0 or -3.0) returns 0 and sets `out_invalid`. A value strictly between -1 and 0 returns 0 with only `out_inexact`. Positive values above the unsigned maximum clamp to all ones and set `out_invalid`.
- R5: A NaN of either sign returns the largest positive value of the format and sets `out_invalid`: 0x7FFFFFFF for signed 32, 0x7FFFFFFFFFFFFFFF for signed 64, and all ones for both unsigned formats.
- R6: Positive infinity returns the format maximum. Negative infinity returns the signed minimum, or 0 for unsigned formats. Both set `out_invalid`.
- R7: Every 32-bit result is sign-extended from bit 31 to 64 bits, including unsigned results. For example, 3e9 converted to unsigned 32 gives 0xFFFFFFFFB2D05E00.
- R8: The format code uses bit 0 to select unsigned and bit 1 to select a 64-bit destination: 00 is signed 32, 01 is unsigned 32, 10 is signed 64 and 11 is unsigned 64. A 64-bit signed conversion of 3e9 or -3e9 is exact, and an unsigned 64-bit conversion of 3e9 gives 3000000000.
- R9: Positive and negative zero give 0 with no flag. Any subnormal input gives 0 with `out_inexact`.
- R10: When `out_invalid` is set, `out_inexact` is clear, even if fraction bits were discarded.
- R11: A result appears with `out_valid` exactly 1+`MID_REG` cycles after its `in_valid` (2 cycles by default). While `out_valid` is low, `out_data` and both flags are 0. Reset clears `out_valid`, `out_data` and the flags.
- R12: Operands presented on consecutive cycles each produce their own correct result in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | FP_W | Floating-point operand |
| in_fmt | input | 2 | Destination format code (bit 0 unsigned, bit 1 64-bit) |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | INT_W | Integer result, 32-bit formats sign-extended |
| out_invalid | output | 1 | Input was NaN or out of range |
| out_inexact | output | 1 | Nonzero fraction discarded on an in-range result |

## Verification
The assertions compare each output with the operand and format sampled 1+`MID_REG` cycles earlier. They are only armed once that many cycles have passed since reset, so they assume `in_valid` was held low during reset and that the inputs are stable at each clock edge. The bench holds `in_valid` low during reset and changes the inputs only on the falling edge. Its directed operands cover every NaN, infinity, zero, subnormal and range-edge case that the assertions describe. Its random operands concentrate their exponents near the integer width, so the clamping and sign-extension rules are exercised continuously.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
   // Destination format: bit 0 selects unsigned, bit 1 selects the wide destination.
   typedef enum logic [1:0] {
      FMT_S_NARROW = 2'b00,
      FMT_U_NARROW = 2'b01,
      FMT_S_WIDE   = 2'b10,
      FMT_U_WIDE   = 2'b11
   } d2i_fmt_e;

   function automatic logic fmt_unsigned(input logic [1:0] f);
      return f[0];
   endfunction

   function automatic logic fmt_narrow(input logic [1:0] f);
      return ~f[1];
   endfunction
endpackage

// File: rtl/d2i_unpack.sv
// Splits the operand into its fields and aligns the significand so that the
// integer part and the discarded fraction fall out of a single left shift.
module d2i_unpack #(
   parameter int FP_W  = 64,
   parameter int EXP_W = 11,
   parameter int INT_W = 64
) (
   input  logic [FP_W-1:0]  fp,
   output logic             sign,
   output logic             is_nan,
   output logic             is_big,
   output logic [INT_W-1:0] mag,
   output logic             sticky
);
   localparam int MAN_W  = FP_W - EXP_W - 1;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int SH_W   = $clog2(INT_W);
   localparam int WIDE_W = INT_W + MAN_W;

   logic [EXP_W-1:0]  exp_f;
   logic [MAN_W-1:0]  man;
   logic              below_one;
   logic [SH_W-1:0]   shamt;
   logic [WIDE_W-1:0] wide;

   assign sign   = fp[FP_W-1];
   assign exp_f  = fp[FP_W-2 -: EXP_W];
   assign man    = fp[MAN_W-1:0];

   assign is_nan    = (&exp_f) && (|man);
   assign below_one = exp_f < EXP_W'(BIAS);
   assign is_big    = {1'b0, exp_f} >= (EXP_W+1)'(BIAS + INT_W);

   // Unbiased exponent is 0 .. INT_W-1 whenever the shift result is used.
   assign shamt = SH_W'(exp_f - EXP_W'(BIAS));
   assign wide  = WIDE_W'({1'b1, man}) << shamt;

   always_comb begin
      if (below_one) begin
         mag    = '0;
         sticky = (|exp_f) || (|man);
      end else if (is_big) begin
         mag    = '0;
         sticky = 1'b0;
      end else begin
         mag    = wide[WIDE_W-1:MAN_W];
         sticky = |wide[MAN_W-1:0];
      end
   end
endmodule

// File: rtl/d2i_sat.sv
// Range check on the unsigned magnitude, clamping, negation and narrow
// sign extension, plus the two flags.
module d2i_sat #(
   parameter int INT_W = 64
) (
   input  logic [1:0]       fmt,
   input  logic             sign,
   input  logic             is_nan,
   input  logic             is_big,
   input  logic [INT_W-1:0] mag,
   input  logic             sticky,
   output logic [INT_W-1:0] res,
   output logic             inv,
   output logic             inx
);
   import d2i_pkg::*;

   localparam int HALF_W = INT_W / 2;

   localparam logic [INT_W-1:0] ONES      = '1;
   localparam logic [INT_W-1:0] ZERO      = '0;
   localparam logic [INT_W-1:0] N_S_MAX   = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
   localparam logic [INT_W-1:0] N_S_NEGM  = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
   localparam logic [INT_W-1:0] N_S_MIN   = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
   localparam logic [INT_W-1:0] N_U_MAX   = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
   localparam logic [INT_W-1:0] W_S_MAX   = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] W_S_MIN   = {1'b1, {(INT_W-1){1'b0}}};

   d2i_fmt_e         fmt_e;
   logic [INT_W-1:0] pos_lim, neg_lim, max_val, min_val;
   logic [INT_W-1:0] signed_val, fit_val;
   logic             over;

   assign fmt_e = d2i_fmt_e'(fmt);

   always_comb begin
      unique case (fmt_e)
         FMT_S_NARROW: begin
            pos_lim = N_S_MAX;  neg_lim = N_S_NEGM;
            max_val = N_S_MAX;  min_val = N_S_MIN;
         end
         FMT_U_NARROW: begin
            pos_lim = N_U_MAX;  neg_lim = ZERO;
            max_val = ONES;     min_val = ZERO;
         end
         FMT_S_WIDE: begin
            pos_lim = W_S_MAX;  neg_lim = W_S_MIN;
            max_val = W_S_MAX;  min_val = W_S_MIN;
         end
         FMT_U_WIDE: begin
            pos_lim = ONES;     neg_lim = ZERO;
            max_val = ONES;     min_val = ZERO;
         end
      endcase
   end

   assign over       = is_big || (sign ? (mag > neg_lim) : (mag > pos_lim));
   assign inv        = is_nan || over;
   assign inx        = !inv && sticky;
   assign signed_val = sign ? (~mag + 1'b1) : mag;
   assign fit_val    = fmt_narrow(fmt)
                       ? {{HALF_W{signed_val[HALF_W-1]}}, signed_val[HALF_W-1:0]}
                       : signed_val;

   always_comb begin
      if (!inv)                 res = fit_val;
      else if (is_nan || !sign) res = max_val;
      else                      res = min_val;
   end
endmodule

// File: rtl/d2i_convert.sv
module d2i_convert #(
   parameter int FP_W    = 64,
   parameter int EXP_W   = 11,
   parameter int INT_W   = 64,
   parameter int MID_REG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [FP_W-1:0]  in_data,
   input  logic [1:0]       in_fmt,
   output logic             out_valid,
   output logic [INT_W-1:0] out_data,
   output logic             out_invalid,
   output logic             out_inexact
);
   localparam int MAN_W = FP_W - EXP_W - 1;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

   if (INT_W % 2 != 0 || INT_W < 4) begin : g_bad_int_w
      $error("d2i_convert: INT_W must be even and at least 4");
   end
   if (MAN_W < 1 || EXP_W < 2) begin : g_bad_fp_w
      $error("d2i_convert: floating-point field widths are inconsistent");
   end
   if (BIAS + INT_W >= (1 << EXP_W) - 1) begin : g_bad_range
      $error("d2i_convert: exponent range too small for INT_W");
   end
   if (MID_REG != 0 && MID_REG != 1) begin : g_bad_mid
      $error("d2i_convert: MID_REG must be 0 or 1");
   end

   // Stage A: unpack and align
   logic             a_sign, a_nan, a_big, a_sticky;
   logic [INT_W-1:0] a_mag;

   d2i_unpack #(.FP_W(FP_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_unpack (
      .fp     (in_data),
      .sign   (a_sign),
      .is_nan (a_nan),
      .is_big (a_big),
      .mag    (a_mag),
      .sticky (a_sticky)
   );

   // Optional boundary between alignment and clamping
   logic             m_valid, m_sign, m_nan, m_big, m_sticky;
   logic [INT_W-1:0] m_mag;
   logic [1:0]       m_fmt;

   if (MID_REG != 0) begin : g_mid_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_valid  <= 1'b0;
            m_sign   <= 1'b0;
            m_nan    <= 1'b0;
            m_big    <= 1'b0;
            m_sticky <= 1'b0;
            m_mag    <= '0;
            m_fmt    <= '0;
         end else begin
            m_valid  <= in_valid;
            m_sign   <= a_sign;
            m_nan    <= a_nan;
            m_big    <= a_big;
            m_sticky <= a_sticky;
            m_mag    <= a_mag;
            m_fmt    <= in_fmt;
         end
      end
   end else begin : g_mid_wire
      assign m_valid  = in_valid;
      assign m_sign   = a_sign;
      assign m_nan    = a_nan;
      assign m_big    = a_big;
      assign m_sticky = a_sticky;
      assign m_mag    = a_mag;
      assign m_fmt    = in_fmt;
   end

   // Stage B: clamp and flag
   logic [INT_W-1:0] b_res;
   logic             b_inv, b_inx;

   d2i_sat #(.INT_W(INT_W)) u_sat (
      .fmt    (m_fmt),
      .sign   (m_sign),
      .is_nan (m_nan),
      .is_big (m_big),
      .mag    (m_mag),
      .sticky (m_sticky),
      .res    (b_res),
      .inv    (b_inv),
      .inx    (b_inx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid   <= m_valid;
         out_data    <= m_valid ? b_res : '0;
         out_invalid <= m_valid && b_inv;
         out_inexact <= m_valid && b_inx;
      end
   end
endmodule

// File: rtl/d2i_convert_chk.sv
module d2i_convert_chk #(
   parameter int FP_W    = 64,
   parameter int EXP_W   = 11,
   parameter int INT_W   = 64,
   parameter int MID_REG = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [FP_W-1:0]  in_data,
   input logic [1:0]       in_fmt,
   input logic             out_valid,
   input logic [INT_W-1:0] out_data,
   input logic             out_invalid,
   input logic             out_inexact
);
   localparam int LAT    = 1 + MID_REG;
   localparam int MAN_W  = FP_W - EXP_W - 1;
   localparam int HALF_W = INT_W / 2;

   localparam logic [INT_W-1:0] N_S_MAX = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
   localparam logic [INT_W-1:0] W_S_MAX = {1'b0, {(INT_W-1){1'b1}}};

   logic [1:0] seen;
   logic       armed;
   logic       op_nan, op_zero, op_sign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen <= '0;
      else if (seen != 2'(LAT))  seen <= seen + 2'd1;
   end
   assign armed   = seen == 2'(LAT);
   assign op_nan  = (&in_data[FP_W-2:MAN_W]) && (|in_data[MAN_W-1:0]);
   assign op_zero = in_data[FP_W-2:0] == '0;
   assign op_sign = in_data[FP_W-1];

   assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> out_valid == $past(in_valid, LAT));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_invalid && !out_inexact && out_data == '0));

   assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact));

   assert_nan_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid, LAT) && $past(op_nan, LAT)) |->
         (out_invalid && out_data == ($past(in_fmt[0], LAT) ? {INT_W{1'b1}}
                                     : ($past(in_fmt[1], LAT) ? W_S_MAX : N_S_MAX))));

   assert_zero_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid, LAT) && $past(op_zero, LAT)) |->
         (out_data == '0 && !out_invalid && !out_inexact));

   assert_uns_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid, LAT) && $past(op_sign, LAT) && !$past(op_nan, LAT)
             && $past(in_fmt[0], LAT)) |-> out_data == '0);

   assert_narrow_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid, LAT) && !$past(in_fmt[1], LAT)) |->
         out_data[INT_W-1:HALF_W] == {HALF_W{out_data[HALF_W-1]}});
endmodule

bind d2i_convert d2i_convert_chk #(
   .FP_W(FP_W), .EXP_W(EXP_W), .INT_W(INT_W), .MID_REG(MID_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_data     (in_data),
   .in_fmt      (in_fmt),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/sim_d2i_convert.sv
module sim_d2i_convert;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_fmt = '0;
   logic        out_valid, out_invalid, out_inexact;
   logic [63:0] out_data;

   always #2 clk = ~clk;

   d2i_convert u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_fmt(in_fmt),
      .out_valid(out_valid), .out_data(out_data),
      .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   int total = 0;
   int bad = 0;
   bit finished = 0;

   bit          qv[$];
   logic [63:0] qd[$];
   bit          qi[$];
   bit          qx[$];
   string       qt[$];

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Behavioural reference from the requirements.
   function automatic void model(input logic [63:0] x, input logic [1:0] f,
                                 output logic [63:0] d, output bit inv, output bit inx);
      bit s, frac, huge, nan;
      int e, k;
      logic [51:0]  man;
      logic [127:0] sig, mag, lim_p, lim_n;
      logic [63:0]  maxv, minv, r;
      s = x[63]; e = int'(x[62:52]); man = x[51:0];
      sig = {75'b0, 1'b1, man}; mag = '0; frac = 0; huge = 0;
      nan = (e == 2047) && (man != 0);
      k = e - 1023;
      if (k >= 64) huge = 1;
      else if (k < 0) frac = (e != 0) || (man != 0);
      else if (k >= 52) mag = sig << (k - 52);
      else begin
         mag  = sig >> (52 - k);
         frac = (sig & ((128'd1 << (52 - k)) - 128'd1)) != 0;
      end
      case (f)
         2'b00: begin lim_p = (128'd1 << 31) - 1; lim_n = 128'd1 << 31;
                      maxv = 64'h7FFFFFFF; minv = 64'hFFFFFFFF80000000; end
         2'b01: begin lim_p = (128'd1 << 32) - 1; lim_n = 0;
                      maxv = '1; minv = 0; end
         2'b10: begin lim_p = (128'd1 << 63) - 1; lim_n = 128'd1 << 63;
                      maxv = 64'h7FFFFFFFFFFFFFFF; minv = 64'h8000000000000000; end
         default: begin lim_p = (128'd1 << 64) - 1; lim_n = 0;
                      maxv = '1; minv = 0; end
      endcase
      if (nan) begin d = maxv; inv = 1; inx = 0; end
      else if (huge || (s ? mag > lim_n : mag > lim_p)) begin
         d = s ? minv : maxv; inv = 1; inx = 0;
      end else begin
         r = s ? -mag[63:0] : mag[63:0];
         if (!f[1]) r = {{32{r[31]}}, r[31:0]};
         d = r; inv = 0; inx = frac;
      end
   endfunction

   task automatic compare_front();
      if (qv.size() == LAT) begin
         bit v, ei, ex; logic [63:0] ed; string t;
         v = qv.pop_front(); ed = qd.pop_front(); ei = qi.pop_front();
         ex = qx.pop_front(); t = qt.pop_front();
         chk(t, "out_valid", 64'(out_valid), 64'(v));
         if (v) begin
            chk(t, "out_data", out_data, ed);
            chk(t, "out_invalid", 64'(out_invalid), 64'(ei));
            chk(t, "out_inexact", 64'(out_inexact), 64'(ex));
         end else begin
            chk("R11", "idle flags", {62'b0, out_invalid, out_inexact}, 64'd0);
         end
      end
   endtask

   task automatic step(bit v, logic [63:0] x, logic [1:0] f,
                       logic [63:0] ed, bit ei, bit ex, string tag);
      @(negedge clk);
      compare_front();
      in_valid = v; in_data = x; in_fmt = f;
      qv.push_back(v); qd.push_back(ed); qi.push_back(ei); qx.push_back(ex); qt.push_back(tag);
   endtask

   task automatic dir(real rv, logic [1:0] f, logic [63:0] ed, bit ei, bit ex, string tag);
      step(1'b1, $realtobits(rv), f, ed, ei, ex, tag);
   endtask

   task automatic dirb(logic [63:0] x, logic [1:0] f, logic [63:0] ed, bit ei, bit ex, string tag);
      step(1'b1, x, f, ed, ei, ex, tag);
   endtask

   localparam logic [63:0] ONES = '1;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // Reset state (R11)
      repeat (3) begin
         @(negedge clk);
         chk("R11", "reset out_valid", 64'(out_valid), 64'd0);
         chk("R11", "reset out_data", out_data, 64'd0);
         chk("R11", "reset flags", {62'b0, out_invalid, out_inexact}, 64'd0);
      end
      rst_n = 1'b1;

      // R1 truncation, R2 exactness (codes: 00 s32, 01 u32, 10 s64, 11 u64 per R8)
      dir( 1.1, 2'b00, 64'd1, 0, 1, "R1");
      dir(-1.1, 2'b00, ONES, 0, 1, "R1");
      dir(-0.9, 2'b10, 64'd0, 0, 1, "R1");
      dir( 0.9, 2'b01, 64'd0, 0, 1, "R1");
      dir(-1.1, 2'b10, ONES, 0, 1, "R2");
      dir(-1.0, 2'b00, ONES, 0, 0, "R2");
      dir( 1.0, 2'b11, 64'd1, 0, 0, "R2");
      // R3 signed clamping and edges
      dir(-3e9, 2'b00, 64'hFFFFFFFF80000000, 1, 0, "R3");
      dir( 3e9, 2'b00, 64'h000000007FFFFFFF, 1, 0, "R3");
      dir(-3e19, 2'b10, 64'h8000000000000000, 1, 0, "R3");
      dir( 3e19, 2'b10, 64'h7FFFFFFFFFFFFFFF, 1, 0, "R3");
      dir( 2147483647.0, 2'b00, 64'h7FFFFFFF, 0, 0, "R3");
      dir( 2147483648.0, 2'b00, 64'h7FFFFFFF, 1, 0, "R3");
      dir(-2147483648.0, 2'b00, 64'hFFFFFFFF80000000, 0, 0, "R3");
      dir(-2147483648.9, 2'b00, 64'hFFFFFFFF80000000, 0, 1, "R3");
      dirb(64'h43E0000000000000, 2'b10, 64'h7FFFFFFFFFFFFFFF, 1, 0, "R3");
      dirb(64'hC3E0000000000000, 2'b10, 64'h8000000000000000, 0, 0, "R3");
      // R4 unsigned negatives and upper edge
      dir(-3.0, 2'b01, 64'd0, 1, 0, "R4");
      dir(-1.0, 2'b11, 64'd0, 1, 0, "R4");
      dir(-0.9, 2'b11, 64'd0, 0, 1, "R4");
      dir(4294967295.0, 2'b01, ONES, 0, 0, "R4");
      dirb(64'h43F0000000000000, 2'b11, ONES, 1, 0, "R4");
      dirb(64'h43EFFFFFFFFFFFFF, 2'b11, 64'hFFFFFFFFFFFFF800, 0, 0, "R4");
      // R5 NaN
      dirb(64'hFFFFFFFFFFFFFFFF, 2'b00, 64'h7FFFFFFF, 1, 0, "R5");
      dirb(64'h7FFFFFFFFFFFFFFF, 2'b10, 64'h7FFFFFFFFFFFFFFF, 1, 0, "R5");
      dirb(64'hFFF8000000000000, 2'b01, ONES, 1, 0, "R5");
      dirb(64'h7FF0000000000001, 2'b11, ONES, 1, 0, "R5");
      // R6 infinities
      dirb(64'hFFF0000000000000, 2'b00, 64'hFFFFFFFF80000000, 1, 0, "R6");
      dirb(64'h7FF0000000000000, 2'b10, 64'h7FFFFFFFFFFFFFFF, 1, 0, "R6");
      dirb(64'hFFF0000000000000, 2'b11, 64'd0, 1, 0, "R6");
      dirb(64'h7FF0000000000000, 2'b01, ONES, 1, 0, "R6");
      dirb(64'hFFF0000000000000, 2'b10, 64'h8000000000000000, 1, 0, "R6");
      // R7 narrow sign extension, R8 wide formats
      dir( 3e9, 2'b01, 64'hFFFFFFFFB2D05E00, 0, 0, "R7");
      dir( 3e9, 2'b11, 64'd3000000000, 0, 0, "R8");
      dir( 3e9, 2'b10, 64'd3000000000, 0, 0, "R8");
      dir(-3e9, 2'b10, -64'sd3000000000, 0, 0, "R8");
      // R9 zeros and subnormals
      dirb(64'h0000000000000000, 2'b00, 64'd0, 0, 0, "R9");
      dirb(64'h8000000000000000, 2'b01, 64'd0, 0, 0, "R9");
      dirb(64'h000FFFFFFFFFFFFF, 2'b10, 64'd0, 0, 1, "R9");
      dirb(64'h800FFFFFFFFFFFFF, 2'b11, 64'd0, 0, 1, "R9");
      // R10 invalid suppresses inexact
      dir(4294967296.5, 2'b01, ONES, 1, 0, "R10");
      dir(-2.5, 2'b01, 64'd0, 1, 0, "R10");
      dir(-2147483649.5, 2'b00, 64'hFFFFFFFF80000000, 1, 0, "R10");
      // R11 gap then one isolated operand
      step(1'b0, '0, '0, '0, 0, 0, "R11");
      dir(7.75, 2'b00, 64'd7, 0, 1, "R11");
      step(1'b0, '0, '0, '0, 0, 0, "R11");
      step(1'b0, '0, '0, '0, 0, 0, "R11");

      // R12 streaming random operands against the reference model
      for (int n = 0; n < 4000; n++) begin
         logic [63:0] x, ed; logic [1:0] f; bit v, ei, ex;
         x = {$urandom, $urandom};
         if ($urandom_range(0, 3) != 0) x[62:52] = 11'(990 + $urandom_range(0, 110));
         f = 2'($urandom_range(0, 3));
         v = ($urandom_range(0, 9) != 0);
         model(x, f, ed, ei, ex);
         step(v, x, f, ed, ei, ex, "R12");
      end
      repeat (LAT) step(1'b0, '0, '0, '0, 0, 0, "R11");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule